// File: doc/BRIEF.md
# Collision-Vector Initiation Scheduler

This block is the start controller for a pipeline whose stages are not used in a simple front-to-back order. A task may claim the same stage in several of its cycles. Starting a second task too soon can then make two tasks want one stage in the same cycle. The block holds the pipeline's collision vector and uses it to decide, each clock, whether a waiting start request may go ahead.

The vector is loaded once and held. Its bit i-1 is 1 when a start i cycles after another start would collide. The live state register moves one place toward bit 0 every clock. Bit 0 always describes the distance since the most recent start. A request is granted when that bit is clear. Each grant merges the loaded vector into the shifted state.

Alongside the scheduling, the block keeps two saturating totals: the number of starts, and the sum of the distances between consecutive starts. Software or a monitor can divide the sum by the number of distances to get the average start interval.

Top module: `cvs_sched`

## Requirements
- R1: After reset the state reads all zeros, the latency sum and the start count read zero, and the loaded vector is zero; the first request after reset is granted in the same cycle.
- R2: `grant` is high in a cycle exactly when `req` is high and bit 0 of `state` is 0; bit k of `state` set means a start at distance k+1 from earlier starts, counted from the current cycle, is forbidden.
- R3: In a cycle without a grant, `state` moves right by one place at the clock edge, with 0 entering the top bit.
- R4: In a cycle with a grant, the next `state` is the right-shifted state ORed with the loaded vector; with vector 1011010 (bit 6 down to bit 0), a grant one cycle after the previous start gives state 1111111.
- R5: A refused request starts nothing: the start count and the latency sum keep their values, the state still shifts, and the same request may be granted in a later cycle.
- R6: A request made more than `CV_W` cycles after the last start, or while `state` is all zeros, is always granted.
- R7: A high `cv_load` captures `cv_in` as the loaded vector at the clock edge; a grant in that same cycle still merges the previously loaded vector; loading never alters `state`.
- R8: Each grant adds one to `start_cnt`, which holds at 2^CNT_W-1 instead of wrapping.
- R9: Each grant after the first since reset adds the number of cycles since the previous grant to `lat_sum`; that distance stops counting at 2^GAP_W-1, and the sum holds at 2^SUM_W-1 instead of wrapping.
- R10: With vector 1011010 and a request held high, grants alternate at distances 1 and 8, the state returns to 1011010 after each distance-8 start, and after five starts `lat_sum` is 18 (average 4.5 over four distances).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cv_load | input | 1 | Capture `cv_in` as the collision vector |
| cv_in | input | CV_W | Collision vector; bit i-1 forbids distance i |
| req | input | 1 | Request to start a task this cycle |
| grant | output | 1 | Start permitted this cycle |
| state | output | CV_W | Current state vector |
| lat_sum | output | SUM_W | Saturating sum of distances between starts |
| start_cnt | output | CNT_W | Saturating count of starts |

## Verification
The bench holds the request high under the example vector. A design that ORed the vector in before shifting, or that tested the wrong end of the state, would break the 1,8 alternation and would not return to 1011010. It also probes a forbidden distance of 2 and a permitted distance of 3, and reloads the vector while the state is busy. These cases catch a state that is cleared or overwritten on a load, and a grant that wrongly picks up the new vector in the load cycle. Long runs drive the start count and the sum into saturation, and idle gaps hold the distance counter at its ceiling, so a counter that wraps shows up as a small value where the maximum is expected.

// File: rtl/cvs_pkg.sv
`timescale 1ns/1ps
package cvs_pkg;

    // Start event passed from the control path to the accumulators.
    typedef struct packed {
        logic fire;      // a task starts this cycle
        logic has_prev;  // an earlier start exists since reset
    } issue_t;

endpackage

// File: rtl/cvs_state.sv
`timescale 1ns/1ps
module cvs_state #(
    parameter int CV_W = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cv_load,
    input  logic [CV_W-1:0] cv_in,
    input  logic            req,
    output logic            grant,
    output logic [CV_W-1:0] state,
    output logic [CV_W-1:0] cv_q
) ;

    logic [CV_W-1:0] st_q;
    logic [CV_W-1:0] st_nxt;

    // Bit 0 describes the distance to the current cycle.
    assign grant = req & ~st_q[0];

    // Per bit: take the neighbour above, merge the vector on a start.
    for (genvar k = 0; k < CV_W; k++) begin : g_bit
        if (k == CV_W - 1) begin : g_top
            assign st_nxt[k] = grant & cv_q[k];
        end else begin : g_mid
            assign st_nxt[k] = st_q[k+1] | (grant & cv_q[k]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
            cv_q <= '0;
        end else begin
            st_q <= st_nxt;
            if (cv_load) begin
                cv_q <= cv_in;
            end
        end
    end

    assign state = st_q;

endmodule

// File: rtl/cvs_gap.sv
`timescale 1ns/1ps
module cvs_gap #(
    parameter int GAP_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fire,
    output logic [GAP_W-1:0] gap,
    output logic             seen
);

    localparam logic [GAP_W-1:0] GAP_MAX = {GAP_W{1'b1}};

    logic [GAP_W-1:0] gap_q;
    logic             seen_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap_q  <= '0;
            seen_q <= 1'b0;
        end else if (fire) begin
            gap_q  <= {{(GAP_W-1){1'b0}}, 1'b1};
            seen_q <= 1'b1;
        end else if (gap_q != GAP_MAX) begin
            gap_q  <= gap_q + 1'b1;
        end
    end

    assign gap  = gap_q;
    assign seen = seen_q;

endmodule

// File: rtl/cvs_accum.sv
`timescale 1ns/1ps
module cvs_accum
    import cvs_pkg::*;
#(
    parameter int GAP_W = 16,
    parameter int SUM_W = 32,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  issue_t           ev,
    input  logic [GAP_W-1:0] gap,
    output logic [SUM_W-1:0] lat_sum,
    output logic [CNT_W-1:0] start_cnt
);

    localparam logic [SUM_W-1:0] SUM_MAX = {SUM_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [SUM_W-1:0] sum_q;
    logic [CNT_W-1:0] cnt_q;
    logic [SUM_W:0]   sum_wide;
    logic [SUM_W-1:0] sum_sat;

    // One extra bit catches the carry; a carry pins the sum at its top.
    assign sum_wide = {1'b0, sum_q} + (SUM_W+1)'(gap);
    assign sum_sat  = sum_wide[SUM_W] ? SUM_MAX : sum_wide[SUM_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            sum_q <= '0;
            cnt_q <= '0;
        end else if (ev.fire) begin
            if (cnt_q != CNT_MAX) begin
                cnt_q <= cnt_q + 1'b1;
            end
            if (ev.has_prev) begin
                sum_q <= sum_sat;
            end
        end
    end

    assign lat_sum   = sum_q;
    assign start_cnt = cnt_q;

endmodule

// File: rtl/cvs_sched.sv
`timescale 1ns/1ps
module cvs_sched
    import cvs_pkg::*;
#(
    parameter int CV_W  = 16,
    parameter int GAP_W = 16,
    parameter int SUM_W = 32,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cv_load,
    input  logic [CV_W-1:0]  cv_in,
    input  logic             req,
    output logic             grant,
    output logic [CV_W-1:0]  state,
    output logic [SUM_W-1:0] lat_sum,
    output logic [CNT_W-1:0] start_cnt
);

    logic [CV_W-1:0]  cv_q;
    logic [GAP_W-1:0] gap;
    logic             seen;
    issue_t           ev;

    cvs_state #(.CV_W(CV_W)) u_state (
        .clk     (clk),
        .rst     (rst),
        .cv_load (cv_load),
        .cv_in   (cv_in),
        .req     (req),
        .grant   (grant),
        .state   (state),
        .cv_q    (cv_q)
    );

    cvs_gap #(.GAP_W(GAP_W)) u_gap (
        .clk  (clk),
        .rst  (rst),
        .fire (grant),
        .gap  (gap),
        .seen (seen)
    );

    assign ev.fire     = grant;
    assign ev.has_prev = seen;

    cvs_accum #(.GAP_W(GAP_W), .SUM_W(SUM_W), .CNT_W(CNT_W)) u_accum (
        .clk       (clk),
        .rst       (rst),
        .ev        (ev),
        .gap       (gap),
        .lat_sum   (lat_sum),
        .start_cnt (start_cnt)
    );

endmodule

// File: rtl/cvs_sched_chk.sv
`timescale 1ns/1ps
module cvs_sched_chk #(
    parameter int CV_W  = 16,
    parameter int SUM_W = 32,
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             req,
    input logic             grant,
    input logic [CV_W-1:0]  state,
    input logic [CV_W-1:0]  cv_q,
    input logic [SUM_W-1:0] lat_sum,
    input logic [CNT_W-1:0] start_cnt
);

    localparam logic [SUM_W-1:0] SUM_MAX = {SUM_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    AST_GRANT_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
        grant |-> req); // R2

    AST_NO_HIT: assert property (@(posedge clk) disable iff (rst)
        grant |-> !state[0]); // R2

    AST_SHIFT_IDLE: assert property (@(posedge clk) disable iff (rst)
        !grant |=> state == ($past(state) >> 1)); // R3

    AST_MERGE_VEC: assert property (@(posedge clk) disable iff (rst)
        grant |=> (state & $past(cv_q)) == $past(cv_q)); // R4

    AST_REFUSE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !grant |=> (start_cnt == $past(start_cnt)) && (lat_sum == $past(lat_sum))); // R5

    AST_IDLE_GRANT: assert property (@(posedge clk) disable iff (rst)
        (req && state == '0) |-> grant); // R6

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (grant && start_cnt != CNT_MAX) |=> start_cnt == $past(start_cnt) + 1'b1); // R8

    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (start_cnt == CNT_MAX) |=> start_cnt == CNT_MAX); // R8

    AST_SUM_HOLD: assert property (@(posedge clk) disable iff (rst)
        (lat_sum == SUM_MAX) |=> lat_sum == SUM_MAX); // R9

    AST_SUM_MONO: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> lat_sum >= $past(lat_sum)); // R9

endmodule

bind cvs_sched cvs_sched_chk #(.CV_W(CV_W), .SUM_W(SUM_W), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req       (req),
    .grant     (grant),
    .state     (state),
    .cv_q      (cv_q),
    .lat_sum   (lat_sum),
    .start_cnt (start_cnt)
);

// File: tb/cvs_sched_tb.sv
`timescale 1ns/1ps
module cvs_sched_tb;

    localparam int CV_W  = 7;
    localparam int GAP_W = 8;
    localparam int SUM_W = 10;
    localparam int CNT_W = 8;
    localparam int GAP_MAX = (1 << GAP_W) - 1;
    localparam int SUM_MAX = (1 << SUM_W) - 1;
    localparam int CNT_MAX = (1 << CNT_W) - 1;
    localparam logic [CV_W-1:0] VEC_A = 7'b1011010;
    localparam logic [CV_W-1:0] VEC_B = 7'b0000101;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             cv_load = 1'b0;
    logic [CV_W-1:0]  cv_in = '0;
    logic             req = 1'b0;
    logic             grant;
    logic [CV_W-1:0]  state;
    logic [SUM_W-1:0] lat_sum;
    logic [CNT_W-1:0] start_cnt;

    cvs_sched #(.CV_W(CV_W), .GAP_W(GAP_W), .SUM_W(SUM_W), .CNT_W(CNT_W)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .cv_load   (cv_load),
        .cv_in     (cv_in),
        .req       (req),
        .grant     (grant),
        .state     (state),
        .lat_sum   (lat_sum),
        .start_cnt (start_cnt)
    );

    always #4 clk = ~clk; // 125 MHz

    typedef struct {
        logic            grant;
        logic [CV_W-1:0] st;
        int              sum;
        int              cnt;
        string           tag;
    } item_t;

    item_t q[$];
    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    // Reference state, written from the requirements.
    logic [CV_W-1:0] m_st  = '0;
    logic [CV_W-1:0] m_cv  = '0;
    int              m_gap = 0;
    bit              m_seen = 1'b0;
    int              m_sum = 0;
    int              m_cnt = 0;

    task automatic check_val(input string tag, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Driver: called just after a falling edge; records the expectation
    // for this cycle, drives inputs, then advances the reference.
    task automatic step(input logic r, input logic ld, input logic [CV_W-1:0] v, input string tag);
        item_t it;
        logic  g;
        g = r & ~m_st[0];
        it.grant = g;
        it.st    = m_st;
        it.sum   = m_sum;
        it.cnt   = m_cnt;
        it.tag   = tag;
        q.push_back(it);
        req     = r;
        cv_load = ld;
        cv_in   = v;
        m_st = (m_st >> 1) | (g ? m_cv : '0);
        if (ld) m_cv = v;
        if (g) begin
            if (m_cnt < CNT_MAX) m_cnt++;
            if (m_seen) m_sum = (m_sum + m_gap > SUM_MAX) ? SUM_MAX : m_sum + m_gap;
            m_gap  = 1;
            m_seen = 1'b1;
        end else if (m_gap < GAP_MAX) begin
            m_gap++;
        end
        @(negedge clk);
    endtask

    // Monitor: pops one expectation per cycle, away from the edge.
    initial begin
        item_t it;
        forever begin
            @(negedge clk);
            #2;
            while (q.size() > 0) begin
                it = q.pop_front();
                check_val(it.tag, "grant", int'(grant), int'(it.grant));
                check_val(it.tag, "state", int'(state), int'(it.st));
                check_val(it.tag, "lat_sum", int'(lat_sum), it.sum);
                check_val(it.tag, "start_cnt", int'(start_cnt), it.cnt);
            end
        end
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset values
        step(1'b0, 1'b0, '0, "R1");
        step(1'b0, 1'b0, '0, "R1");
        // R7: load the example vector
        step(1'b0, 1'b1, VEC_A, "R7");
        // R1: first request granted
        step(1'b1, 1'b0, '0, "R1");
        // R4: distance 1 gives 1111111
        step(1'b1, 1'b0, '0, "R4");
        // R5: refused while bit 0 is set
        for (int i = 0; i < 7; i++) step(1'b1, 1'b0, '0, "R5");
        // R10: distance 8 restores the vector, then repeat 1,8
        step(1'b1, 1'b0, '0, "R10");
        step(1'b1, 1'b0, '0, "R10");
        for (int i = 0; i < 7; i++) step(1'b1, 1'b0, '0, "R10");
        step(1'b1, 1'b0, '0, "R10");
        step(1'b0, 1'b0, '0, "R10");
        // R2: distance 2 forbidden, distance 3 allowed (counted from the
        // grant above)
        step(1'b1, 1'b0, '0, "R2");
        step(1'b1, 1'b0, '0, "R2");
        // R3: idle shifting to empty
        for (int i = 0; i < 10; i++) step(1'b0, 1'b0, '0, "R3");
        // R6: long gap always granted
        step(1'b1, 1'b0, '0, "R6");
        step(1'b0, 1'b0, '0, "R3");
        // R7: load during busy state, and load in a grant cycle
        step(1'b0, 1'b1, VEC_B, "R7");
        step(1'b1, 1'b0, '0, "R7");
        for (int i = 0; i < 9; i++) step(1'b0, 1'b0, '0, "R7");
        step(1'b1, 1'b1, 7'b0000000, "R7");
        step(1'b1, 1'b0, '0, "R7");
        step(1'b1, 1'b0, '0, "R7");
        for (int i = 0; i < 8; i++) step(1'b0, 1'b0, '0, "R6");
        // R8: back-to-back grants into count saturation
        for (int i = 0; i < 300; i++) step(1'b1, 1'b0, '0, "R8");
        // R9: distance ceiling and sum saturation
        for (int k = 0; k < 3; k++) begin
            for (int i = 0; i < 300; i++) step(1'b0, 1'b0, '0, "R9");
            step(1'b1, 1'b0, '0, "R9");
        end
        for (int i = 0; i < 4; i++) step(1'b0, 1'b0, '0, "R9");
        @(negedge clk);
        #3;
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule